// File: doc/BRIEF.md
# Multiplexed Bus Cycle Capture

This block watches the memory bus of a small 8-bit processor that sends a 16-bit address over an 8-bit set of pins in two halves. A first timing strobe marks the moment the pins carry the upper address byte. A second timing strobe marks the moment they carry the lower byte, and at that same point the data bus carries a valid byte. The block rebuilds the full address and records the data byte of each memory cycle. The data byte is kept only when the read strobe or the write strobe is active.

Every input arrives asynchronously and passes through a two-flop synchroniser into the system clock domain. Edges are then detected on the synchronised strobes. The results are a held address register, a held data register and one-cycle event pulses. The pulses are valid-only: the processor on the watched bus cannot be stalled, so there is no ready input and no back-pressure. A consumer must take each pulse in the cycle it appears.

Top module: `bus_cycle_capture`

## Requirements
- R1: While reset is high and in the first cycle after it, addr_o and data_o are zero and addr_evt_o, rd_evt_o and wr_evt_o are low.
- R2: A rising edge of hi_stb_i loads the address pins into addr_o[15:8] and leaves addr_o[7:0] unchanged.
- R3: A rising edge of lo_stb_i loads the address pins into addr_o[7:0] and leaves addr_o[15:8] unchanged.
- R4: On a rising edge of lo_stb_i the data pins are stored into data_o only if rd_n_i or wr_n_i is low; otherwise data_o keeps its value.
- R5: The data pins are wired in reversed bit order, so data_o[i] takes data_pins_i[7-i].
- R6: addr_evt_o is high for exactly one cycle after each rising edge of either strobe. A falling edge of a strobe changes no register and raises no pulse.
- R7: With a rising edge of lo_stb_i, rd_evt_o pulses for one cycle when rd_n_i is low and wr_evt_o pulses when wr_n_i is low. Both pulse if both are low, and neither pulses if both are high.
- R8: An input change applied before a rising clock edge shows on the outputs at the third rising clock edge counting that one, and not before.
- R9: If both strobes rise in the same synchronised cycle, both address halves load from the pins in that cycle and addr_evt_o pulses once.
- R10: A rising edge of hi_stb_i alone leaves data_o unchanged and raises neither rd_evt_o nor wr_evt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hi_stb_i | input | 1 | Strobe for the upper address byte, active high, asynchronous |
| lo_stb_i | input | 1 | Strobe for the lower address byte and data, active high, asynchronous |
| rd_n_i | input | 1 | Memory read strobe, active low |
| wr_n_i | input | 1 | Memory write strobe, active low |
| addr_pins_i | input | 8 | Multiplexed address pins |
| data_pins_i | input | 8 | Data bus pins, reversed bit order |
| addr_o | output | 16 | Rebuilt address |
| data_o | output | 8 | Last captured data byte, in corrected bit order |
| addr_evt_o | output | 1 | One-cycle pulse after any strobe rising edge |
| rd_evt_o | output | 1 | One-cycle pulse for a captured read |
| wr_evt_o | output | 1 | One-cycle pulse for a captured write |

## Verification
Two functions can land in the same cycle. The first case is an upper-byte load and a lower-byte load, when both strobes rise between the same pair of clock edges. The bench drives both strobes high at one falling clock edge and checks that the address becomes the pin byte in both halves, with a single addr_evt_o pulse. The second case is the address load and the read and write flags on one lower strobe edge, including the case where both memory strobes are low. The bench checks that both flags pulse together with addr_evt_o and that the data byte arrives reversed in that same cycle.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef struct packed {
    logic addr;
    logic rd;
    logic wr;
  } evt_t;

  localparam evt_t EVT_NONE = '{addr: 1'b0, rd: 1'b0, wr: 1'b0};
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= RST_VAL;
        else       stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= RST_VAL;
        else       stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= lvl_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end

  // R6: a synchronised strobe cannot rise in two consecutive cycles
  a_r6_rise_single: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o[0] |=> !rise_o[0]);
endmodule

// File: rtl/cycle_capture.sv
module cycle_capture
  import cap_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              hi_rise_i,
  input  logic              lo_rise_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [HALF_W-1:0] pins_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output evt_t              evt_o
);
  logic [HALF_W-1:0] addr_hi_q, addr_lo_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] bus_rev;
  evt_t              evt_q, evt_d;
  logic              take_data;

  // R5: undo the reversed wiring of the data pins
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign bus_rev[i] = bus_i[DATA_W-1-i];
  end

  assign take_data = lo_rise_i && (!rd_n_i || !wr_n_i);

  always_comb begin
    evt_d      = EVT_NONE;
    evt_d.addr = hi_rise_i | lo_rise_i;
    evt_d.rd   = lo_rise_i & ~rd_n_i;
    evt_d.wr   = lo_rise_i & ~wr_n_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      addr_hi_q <= '0;
      addr_lo_q <= '0;
      data_q    <= '0;
      evt_q     <= EVT_NONE;
    end else begin
      if (hi_rise_i) addr_hi_q <= pins_i;
      if (lo_rise_i) addr_lo_q <= pins_i;
      if (take_data) data_q    <= bus_rev;
      evt_q <= evt_d;
    end
  end

  assign addr_o = {addr_hi_q, addr_lo_q};
  assign data_o = data_q;
  assign evt_o  = evt_q;

  a_r2_low_kept: assert property (@(posedge clk_i) disable iff (rst_i)
    (hi_rise_i && !lo_rise_i) |=> (addr_o[HALF_W-1:0] == $past(addr_o[HALF_W-1:0])));
  a_r3_high_kept: assert property (@(posedge clk_i) disable iff (rst_i)
    (lo_rise_i && !hi_rise_i) |=> (addr_o[ADDR_W-1:HALF_W] == $past(addr_o[ADDR_W-1:HALF_W])));
  a_r4_data_held: assert property (@(posedge clk_i) disable iff (rst_i)
    !(lo_rise_i && (!rd_n_i || !wr_n_i)) |=> $stable(data_o));
  a_r6_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (!hi_rise_i && !lo_rise_i) |=> (!evt_o.addr && $stable(addr_o)));
  a_r6_one_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_o.addr |=> !evt_o.addr);
  a_r7_flag_with_addr: assert property (@(posedge clk_i) disable iff (rst_i)
    (evt_o.rd || evt_o.wr) |-> evt_o.addr);
  a_r10_high_no_flags: assert property (@(posedge clk_i) disable iff (rst_i)
    (hi_rise_i && !lo_rise_i) |=> (!evt_o.rd && !evt_o.wr));
endmodule

// File: rtl/bus_cycle_capture.sv
module bus_cycle_capture
  import cap_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = 2 * HALF_W,
  localparam int BUNDLE_W = 4 + HALF_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              hi_stb_i,
  input  logic              lo_stb_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [HALF_W-1:0] addr_pins_i,
  input  logic [DATA_W-1:0] data_pins_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              addr_evt_o,
  output logic              rd_evt_o,
  output logic              wr_evt_o
);
  // strobes idle low, memory strobes idle high
  localparam logic [BUNDLE_W-1:0] IDLE = {2'b00, 2'b11, {(HALF_W + DATA_W){1'b0}}};

  logic [BUNDLE_W-1:0] raw, synced;
  logic              s_hi, s_lo, s_rd_n, s_wr_n;
  logic [HALF_W-1:0] s_pins;
  logic [DATA_W-1:0] s_bus;
  logic [1:0]        rises;
  evt_t              evt;

  assign raw = {hi_stb_i, lo_stb_i, rd_n_i, wr_n_i, addr_pins_i, data_pins_i};

  sync_bank #(.WIDTH(BUNDLE_W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign {s_hi, s_lo, s_rd_n, s_wr_n, s_pins, s_bus} = synced;

  rise_detect #(.WIDTH(2)) u_rise (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  ({s_hi, s_lo}),
    .rise_o (rises)
  );

  cycle_capture #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_cap (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .hi_rise_i (rises[1]),
    .lo_rise_i (rises[0]),
    .rd_n_i    (s_rd_n),
    .wr_n_i    (s_wr_n),
    .pins_i    (s_pins),
    .bus_i     (s_bus),
    .addr_o    (addr_o),
    .data_o    (data_o),
    .evt_o     (evt)
  );

  assign addr_evt_o = evt.addr;
  assign rd_evt_o   = evt.rd;
  assign wr_evt_o   = evt.wr;

  // R1: outputs come out of reset cleared
  a_r1_reset_clear: assert property (@(posedge clk_i)
    $past(rst_i) |-> (addr_o == '0 && data_o == '0 && !addr_evt_o && !rd_evt_o && !wr_evt_o));
endmodule

// File: tb/bus_cycle_capture_tb_top.sv
module bus_cycle_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        hi_stb, lo_stb, rd_n, wr_n;
  logic [7:0]  pins, bus;
  logic [15:0] addr;
  logic [7:0]  data;
  logic        a_evt, r_evt, w_evt;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_addr = '0;
  logic [7:0]  exp_data = '0;

  always #5ns clk = ~clk;

  bus_cycle_capture dut_i (
    .clk_i(clk), .rst_i(rst), .hi_stb_i(hi_stb), .lo_stb_i(lo_stb),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .addr_pins_i(pins), .data_pins_i(bus),
    .addr_o(addr), .data_o(data), .addr_evt_o(a_evt), .rd_evt_o(r_evt), .wr_evt_o(w_evt)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check_state(input string req, input logic ea, input logic er, input logic ew);
    chk({req, " addr"}, {16'h0, addr}, {16'h0, exp_addr});
    chk({req, " data"}, {24'h0, data}, {24'h0, exp_data});
    chk({req, " events"}, {29'h0, a_evt, r_evt, w_evt}, {29'h0, ea, er, ew});
  endtask

  task automatic hi_cycle(input logic [7:0] hb);
    pins = hb;
    step(2);
    hi_stb = 1'b1;
    step(2);
    check_state("R8 before hi update", 1'b0, 1'b0, 1'b0);
    step(1);
    exp_addr[15:8] = hb;
    check_state("R2 R10 hi load", 1'b1, 1'b0, 1'b0);
    step(1);
    check_state("R6 hi pulse end", 1'b0, 1'b0, 1'b0);
    hi_stb = 1'b0;
    step(3);
    check_state("R6 hi fall quiet", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic lo_cycle(input logic [7:0] lb, input logic [7:0] db,
                          input logic rn, input logic wn);
    pins = lb; bus = db; rd_n = rn; wr_n = wn;
    step(2);
    lo_stb = 1'b1;
    step(2);
    check_state("R8 before lo update", 1'b0, 1'b0, 1'b0);
    step(1);
    exp_addr[7:0] = lb;
    if (!rn || !wn) exp_data = rev8(db);
    check_state("R3 R4 R5 R7 lo load", 1'b1, ~rn, ~wn);
    step(1);
    check_state("R6 R7 lo pulse end", 1'b0, 1'b0, 1'b0);
    // falling edge while a memory strobe is low and the bus changes
    bus = ~db;
    lo_stb = 1'b0;
    step(4);
    check_state("R6 lo fall no update", 1'b0, 1'b0, 1'b0);
    rd_n = 1'b1; wr_n = 1'b1;
    step(2);
  endtask

  initial begin
    #1_000_000ns;
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1802));
    rst = 1'b1; hi_stb = 1'b0; lo_stb = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    pins = 8'hA5; bus = 8'h3C;
    @(negedge clk);
    step(3);
    check_state("R1 in reset", 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    step(1);
    check_state("R1 after reset", 1'b0, 1'b0, 1'b0);

    // directed cases
    hi_cycle(8'h12);
    lo_cycle(8'h34, 8'h01, 1'b0, 1'b1);   // read, reversal gives 80
    chk("R5 reversal", {24'h0, data}, 32'h80);
    lo_cycle(8'h56, 8'hC3, 1'b1, 1'b0);   // write
    lo_cycle(8'h78, 8'hF0, 1'b1, 1'b1);   // neither: data kept
    lo_cycle(8'h9A, 8'h5A, 1'b0, 1'b0);   // both flags

    // R9: both strobes rise together
    pins = 8'hE7;
    step(2);
    hi_stb = 1'b1; lo_stb = 1'b1;
    step(3);
    exp_addr = 16'hE7E7;
    check_state("R9 joint load", 1'b1, 1'b0, 1'b0);
    step(1);
    check_state("R9 single pulse", 1'b0, 1'b0, 1'b0);
    hi_stb = 1'b0; lo_stb = 1'b0;
    step(3);

    // random cycles
    for (int k = 0; k < 40; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[0]) hi_cycle(r[15:8]);
      lo_cycle(r[23:16], r[31:24], r[1], r[2]);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule